// File: doc/BRIEF.md
# Control and Debug Register File

This block holds the control, segment-base and debug state of an x86-style core behind one write port and one read port, both addressed by a 6-bit register index. A write is not a plain store. Depending on the index, a write can set the long-mode-active flag, force a control bit to 1, mask a value down to its writable fields, redirect to an alias index, or update the effective segment bases. It can also request TLB flushes, and whether it does depends on which bits changed.

A write enters on a valid/ready channel. `wr_ready` is held high, so the block never applies back-pressure: every cycle with `wr_valid` high commits exactly one write at that clock edge. Reads are combinational on `rd_idx`. The flush requests and the write-error flag are registered single-cycle pulses, raised in the cycle after the write is accepted. The time-stamp counter is kept as an offset from an internal cycle counter that starts at zero after reset.

Index map: CRn = n (0..15); DRn = 16+n (16..23); EFER = 24 (LME bit 8, LMA bit 10); CS attribute = 25 (long-mode bit 0); architectural segment bases = 32..39 and effective bases = 40..47, both in the order ES, CS, SS, DS, FS, GS, TR, IDTR; TSC = 48; FPU status word = 49; FPU stack top = 50. Any other unreserved index reads as zero and ignores writes.

Top module: `cdrf_top`

## Requirements
- R1: A write to CR0 (index 0) that changes bit 31 (PG) while EFER (24) bit 8 is set copies the new PG into EFER bit 10. If bit 8 is clear, EFER is left unchanged.
- R2: A CR0 write that changes bit 31 pulses both full-flush outputs in the next cycle, and a CR0 write that leaves bit 31 alone does not. CR0 bit 4 always reads 1 after any CR0 write.
- R3: Every write to CR3 (index 3) pulses both non-global flush outputs in the next cycle, without the full-flush outputs.
- R4: A CR4 (index 4) write that changes bit 4, 5 or 7 pulses both full-flush outputs in the next cycle. A change of any other CR4 bit does not.
- R5: A CS attribute (25) write that turns bit 0 on clears effective bases 40..43. A write that turns bit 0 off reloads 40..43 from bases 32..35.
- R6: A write to bases 36..39 also writes the matching effective base. A write to bases 32..35 writes the effective base only when EFER bit 10 and CS attribute bit 0 are not both set.
- R7: Index 20 reads and writes DR6 (22). A DR6 write changes only bits 3:0, 13, 14 and 15.
- R8: Index 21 reads and writes DR7 (23). A DR7 write changes only bits 7:0, 13 and 31:16.
- R9: After reset, DR6 reads 0xFFFF0FF0, DR7 reads 0x400, every other register reads 0, and all pulses are low.
- R10: A value V written to TSC (48) reads back as V+k, where k is the number of clock edges since the writing edge (k = 1 right after the write).
- R11: A read of the FPU status word (49) returns the stored word with bits 13:11 replaced by the 3-bit stack top (50).
- R12: Writes to reserved control indices 1, 5..7 and 9..15 change nothing and pulse `wr_err` in the next cycle. Reads of those indices return 0 with `rd_err` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted; held high |
| wr_idx | input | 6 | Write register index |
| wr_data | input | XLEN | Write value |
| rd_idx | input | 6 | Read register index |
| rd_data | output | XLEN | Read value (combinational) |
| rd_err | output | 1 | Read index is a reserved control register |
| wr_err | output | 1 | Pulse: previous write hit a reserved control register |
| itlb_flush_all | output | 1 | Pulse: flush all instruction-TLB entries |
| dtlb_flush_all | output | 1 | Pulse: flush all data-TLB entries |
| itlb_flush_ng | output | 1 | Pulse: flush non-global instruction-TLB entries |
| dtlb_flush_ng | output | 1 | Pulse: flush non-global data-TLB entries |

## Verification
The bench builds the block with its default XLEN of 64. This width brings the upper 32 bits of the debug registers into reach: writing all ones to DR6 and DR7 shows that the masks also keep those upper bits clear. The TSC offset is checked at two distances from the write, which exercises the subtraction in the offset arithmetic. Long-mode entry and exit are driven through both the EFER/CR0 path and the CS attribute, so that the segment-base gating is exercised in 64-bit mode and outside it.

// File: rtl/cdrf_pkg.sv
package cdrf_pkg;
  localparam int IDX_W = 6;
  localparam int NSEG  = 8;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IX_CR0     = 6'd0;
  localparam idx_t IX_CR2     = 6'd2;
  localparam idx_t IX_CR3     = 6'd3;
  localparam idx_t IX_CR4     = 6'd4;
  localparam idx_t IX_CR8     = 6'd8;
  localparam idx_t IX_DR0     = 6'd16;
  localparam idx_t IX_DR4     = 6'd20;
  localparam idx_t IX_DR5     = 6'd21;
  localparam idx_t IX_DR6     = 6'd22;
  localparam idx_t IX_DR7     = 6'd23;
  localparam idx_t IX_EFER    = 6'd24;
  localparam idx_t IX_CSATTR  = 6'd25;
  localparam idx_t IX_SEGBASE = 6'd32;
  localparam idx_t IX_SEGEFF  = 6'd40;
  localparam idx_t IX_TSC     = 6'd48;
  localparam idx_t IX_FSW     = 6'd49;
  localparam idx_t IX_FPTOP   = 6'd50;

  localparam int B_PG   = 31;
  localparam int B_ET   = 4;
  localparam int B_PSE  = 4;
  localparam int B_PAE  = 5;
  localparam int B_PGE  = 7;
  localparam int B_LME  = 8;
  localparam int B_LMA  = 10;
  localparam int B_CSLM = 0;
  localparam int TOP_LO = 11;
  localparam int TOP_W  = 3;

  localparam logic [31:0] DR6_WMASK = 32'h0000_E00F;
  localparam logic [31:0] DR7_WMASK = 32'hFFFF_20FF;
  localparam logic [31:0] DR6_RST   = 32'hFFFF_0FF0;
  localparam logic [31:0] DR7_RST   = 32'h0000_0400;

  function automatic logic is_rsv_cr(idx_t i);
    return (i < 6'd16) && ((i == 6'd1) || (i >= 6'd5 && i <= 6'd7) || (i >= 6'd9));
  endfunction
endpackage

// File: rtl/cdrf_ctrl.sv
module cdrf_ctrl
  import cdrf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  idx_t            wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  idx_t            rd_idx,
  output logic [XLEN-1:0] rd_val,
  output logic            lma,
  output logic            flush_all,
  output logic            flush_ng
);
  logic [XLEN-1:0] cr0, cr2, cr3, cr4, cr8, efer;
  logic pg_tog, cr4_tog;

  assign pg_tog  = cr0[B_PG] ^ wr_data[B_PG];
  assign cr4_tog = (cr4[B_PAE] ^ wr_data[B_PAE]) | (cr4[B_PSE] ^ wr_data[B_PSE]) |
                   (cr4[B_PGE] ^ wr_data[B_PGE]);
  assign lma = efer[B_LMA];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0 <= '0; cr2 <= '0; cr3 <= '0; cr4 <= '0; cr8 <= '0; efer <= '0;
      flush_all <= 1'b0;
      flush_ng  <= 1'b0;
    end else begin
      flush_all <= 1'b0;
      flush_ng  <= 1'b0;
      if (wr_fire) begin
        case (wr_idx)
          IX_CR0: begin
            cr0 <= wr_data | (XLEN'(1) << B_ET);
            if (pg_tog) begin
              flush_all <= 1'b1;
              if (efer[B_LME]) efer[B_LMA] <= wr_data[B_PG];
            end
          end
          IX_CR2: cr2 <= wr_data;
          IX_CR3: begin
            cr3 <= wr_data;
            flush_ng <= 1'b1;
          end
          IX_CR4: begin
            cr4 <= wr_data;
            if (cr4_tog) flush_all <= 1'b1;
          end
          IX_CR8:  cr8  <= wr_data;
          IX_EFER: efer <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_idx)
      IX_CR0:  rd_val = cr0;
      IX_CR2:  rd_val = cr2;
      IX_CR3:  rd_val = cr3;
      IX_CR4:  rd_val = cr4;
      IX_CR8:  rd_val = cr8;
      IX_EFER: rd_val = efer;
      default: rd_val = '0;
    endcase
  end

  p_lma_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IX_CR0 && pg_tog && efer[B_LME]) |=> (efer[B_LMA] == $past(wr_data[B_PG])));
  p_et_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IX_CR0) |=> cr0[B_ET]);
  p_flush_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> ($past(wr_fire) && ($past(wr_idx) == IX_CR0 || $past(wr_idx) == IX_CR4)));
  p_cr3_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IX_CR3) |=> (flush_ng && !flush_all));
endmodule

// File: rtl/cdrf_seg.sv
module cdrf_seg
  import cdrf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  idx_t            wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            lma,
  input  idx_t            rd_idx,
  output logic [XLEN-1:0] rd_val
);
  localparam int NGATED = 4;

  logic [XLEN-1:0] base [NSEG];
  logic [XLEN-1:0] eff  [NSEG];
  logic [XLEN-1:0] cs_attr;
  logic in64;

  assign in64 = lma & cs_attr[B_CSLM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_attr <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base[i] <= '0;
        eff[i]  <= '0;
      end
    end else if (wr_fire) begin
      if (wr_idx == IX_CSATTR) begin
        cs_attr <= wr_data;
        if (cs_attr[B_CSLM] ^ wr_data[B_CSLM]) begin
          for (int i = 0; i < NGATED; i++)
            eff[i] <= wr_data[B_CSLM] ? '0 : base[i];
        end
      end
      for (int i = 0; i < NSEG; i++) begin
        if (wr_idx == idx_t'(IX_SEGBASE + i)) begin
          base[i] <= wr_data;
          if (i >= NGATED || !in64) eff[i] <= wr_data;
        end
        if (wr_idx == idx_t'(IX_SEGEFF + i)) eff[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd_idx == IX_CSATTR) rd_val = cs_attr;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_idx == idx_t'(IX_SEGBASE + i)) rd_val = base[i];
      if (rd_idx == idx_t'(IX_SEGEFF + i))  rd_val = eff[i];
    end
  end

  p_cs_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IX_CSATTR && !cs_attr[B_CSLM] && wr_data[B_CSLM]) |=> (eff[0] == '0 && eff[3] == '0));
  p_cs_off_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IX_CSATTR && cs_attr[B_CSLM] && !wr_data[B_CSLM]) |=> (eff[1] == base[1]));
  p_fs_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == idx_t'(IX_SEGBASE + 4)) |=> (eff[4] == $past(wr_data)));
  p_es_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IX_SEGBASE && in64) |=> $stable(eff[0]));
endmodule

// File: rtl/cdrf_dbg.sv
module cdrf_dbg
  import cdrf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NBP  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  idx_t            wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  idx_t            rd_idx,
  output logic [XLEN-1:0] rd_val
);
  localparam logic [XLEN-1:0] M6 = XLEN'(DR6_WMASK);
  localparam logic [XLEN-1:0] M7 = XLEN'(DR7_WMASK);

  logic [XLEN-1:0] bp [NBP];
  logic [XLEN-1:0] dr6, dr7;
  logic to6, to7, rd6, rd7;

  assign to6 = wr_fire && (wr_idx == IX_DR4 || wr_idx == IX_DR6);
  assign to7 = wr_fire && (wr_idx == IX_DR5 || wr_idx == IX_DR7);
  assign rd6 = (rd_idx == IX_DR4 || rd_idx == IX_DR6);
  assign rd7 = (rd_idx == IX_DR5 || rd_idx == IX_DR7);

  for (genvar g = 0; g < NBP; g++) begin : g_bp
    always_ff @(posedge clk) begin
      if (!rst_n) bp[g] <= '0;
      else if (wr_fire && wr_idx == idx_t'(IX_DR0 + g)) bp[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr6 <= XLEN'(DR6_RST);
      dr7 <= XLEN'(DR7_RST);
    end else begin
      if (to6) dr6 <= (dr6 & ~M6) | (wr_data & M6);
      if (to7) dr7 <= (dr7 & ~M7) | (wr_data & M7);
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NBP; i++)
      if (rd_idx == idx_t'(IX_DR0 + i)) rd_val = bp[i];
    if (rd6) rd_val = dr6;
    if (rd7) rd_val = dr7;
  end

  p_dr6_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    to6 |=> (((dr6 ^ $past(dr6)) & ~M6) == '0));
  p_dr7_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to7 |=> (((dr7 ^ $past(dr7)) & ~M7) == '0));
endmodule

// File: rtl/cdrf_misc.sv
module cdrf_misc
  import cdrf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  idx_t            wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  idx_t            rd_idx,
  output logic [XLEN-1:0] rd_val
);
  localparam logic [XLEN-1:0] TOP_MASK = XLEN'((1 << TOP_W) - 1) << TOP_LO;

  logic [XLEN-1:0]  cyc, tsc_off, fsw;
  logic [TOP_W-1:0] fptop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0; tsc_off <= '0; fsw <= '0; fptop <= '0;
    end else begin
      cyc <= cyc + 1'b1;
      if (wr_fire) begin
        case (wr_idx)
          IX_TSC:   tsc_off <= wr_data - cyc;
          IX_FSW:   fsw     <= wr_data;
          IX_FPTOP: fptop   <= wr_data[TOP_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_idx)
      IX_TSC:   rd_val = tsc_off + cyc;
      IX_FSW:   rd_val = (fsw & ~TOP_MASK) | (XLEN'(fptop) << TOP_LO);
      IX_FPTOP: rd_val = XLEN'(fptop);
      default:  rd_val = '0;
    endcase
  end

  p_tsc_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IX_TSC) |=> ((tsc_off + cyc) == $past(wr_data) + 1'b1));
endmodule

// File: rtl/cdrf_top.sv
module cdrf_top
  import cdrf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [5:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [5:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_err,
  output logic            wr_err,
  output logic            itlb_flush_all,
  output logic            dtlb_flush_all,
  output logic            itlb_flush_ng,
  output logic            dtlb_flush_ng
);
  logic wr_fire, lma, fl_all, fl_ng;
  logic [XLEN-1:0] rv_ctrl, rv_seg, rv_dbg, rv_misc;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  cdrf_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_val(rv_ctrl), .lma(lma), .flush_all(fl_all), .flush_ng(fl_ng));

  cdrf_seg #(.XLEN(XLEN)) u_seg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
    .lma(lma), .rd_idx(rd_idx), .rd_val(rv_seg));

  cdrf_dbg #(.XLEN(XLEN), .NBP(4)) u_dbg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_val(rv_dbg));

  cdrf_misc #(.XLEN(XLEN)) u_misc (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_val(rv_misc));

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_fire && is_rsv_cr(wr_idx);
  end

  assign itlb_flush_all = fl_all;
  assign dtlb_flush_all = fl_all;
  assign itlb_flush_ng  = fl_ng;
  assign dtlb_flush_ng  = fl_ng;
  assign rd_err  = is_rsv_cr(rd_idx);
  assign rd_data = rv_ctrl | rv_seg | rv_dbg | rv_misc;

  p_rsv_wr_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && is_rsv_cr(wr_idx)) |=> (wr_err && !itlb_flush_all && !itlb_flush_ng));
  p_rsv_rd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == '0));
endmodule

// File: tb/test_cdrf_top.sv
module test_cdrf_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [5:0] wr_idx = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic [5:0] rd_idx = '0;
  logic [XLEN-1:0] rd_data;
  logic rd_err, wr_err, itlb_flush_all, dtlb_flush_all, itlb_flush_ng, dtlb_flush_ng;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] s_all, s_ng;
  logic s_err;

  typedef struct {
    logic [5:0]      idx;
    logic [XLEN-1:0] exp;
    string           tag;
  } exp_t;
  exp_t sbq[$];
  event rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdrf_top #(.XLEN(XLEN)) i_cdrf_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_err(rd_err), .wr_err(wr_err), .itlb_flush_all(itlb_flush_all),
    .dtlb_flush_all(dtlb_flush_all), .itlb_flush_ng(itlb_flush_ng),
    .dtlb_flush_ng(dtlb_flush_ng));

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: write, then sample registered pulses at the following falling edge
  task automatic wr(logic [5:0] i, logic [XLEN-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    s_all = {itlb_flush_all, dtlb_flush_all};
    s_ng  = {itlb_flush_ng, dtlb_flush_ng};
    s_err = wr_err;
  endtask

  // driver: push an expected read item for the monitor
  task automatic rd(logic [5:0] i, logic [XLEN-1:0] e, string tag);
    exp_t it;
    it.idx = i; it.exp = e; it.tag = tag;
    rd_idx = i;
    sbq.push_back(it);
    -> rd_ev;
    #2;
  endtask

  // monitor
  initial begin
    forever begin
      @(rd_ev);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check(e.tag, rd_data, e.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 flush pulses", {itlb_flush_all, dtlb_flush_all, itlb_flush_ng, dtlb_flush_ng, wr_err}, '0);
    rd(6'd0,  64'h0, "R9 CR0 reset");
    rd(6'd22, 64'hFFFF_0FF0, "R9 DR6 reset");
    rd(6'd23, 64'h400, "R9 DR7 reset");
    rd(6'd24, 64'h0, "R9 EFER reset");

    // R1 / R2
    wr(6'd24, 64'h100);
    wr(6'd0, 64'h8000_0001);
    check("R2 flush on PG set", s_all, 2'b11);
    rd(6'd24, 64'h500, "R1 LMA set");
    rd(6'd0, 64'h8000_0011, "R2 ET forced");
    wr(6'd0, 64'h8000_0003);
    check("R2 no flush without PG change", s_all, 2'b00);
    wr(6'd0, 64'h1);
    check("R2 flush on PG clear", s_all, 2'b11);
    rd(6'd24, 64'h100, "R1 LMA cleared");
    wr(6'd24, 64'h0);
    wr(6'd0, 64'h8000_0000);
    rd(6'd24, 64'h0, "R1 no LMA without LME");

    // R3
    wr(6'd3, 64'h1000);
    check("R3 nonglobal flush", s_ng, 2'b11);
    check("R3 no full flush", s_all, 2'b00);
    rd(6'd3, 64'h1000, "R3 CR3 stored");

    // R4
    wr(6'd4, 64'h20);
    check("R4 flush on PAE", s_all, 2'b11);
    wr(6'd4, 64'h21);
    check("R4 no flush other bit", s_all, 2'b00);
    wr(6'd4, 64'hA1);
    check("R4 flush on PGE", s_all, 2'b11);
    wr(6'd4, 64'hB1);
    check("R4 flush on PSE", s_all, 2'b11);

    // R6 / R5
    wr(6'd32, 64'h1111);
    rd(6'd40, 64'h1111, "R6 ES eff outside 64-bit");
    wr(6'd35, 64'h4444);
    rd(6'd43, 64'h4444, "R6 DS eff outside 64-bit");
    wr(6'd24, 64'h500);
    wr(6'd25, 64'h1);
    rd(6'd40, 64'h0, "R5 ES eff cleared");
    rd(6'd43, 64'h0, "R5 DS eff cleared");
    wr(6'd32, 64'h2222);
    rd(6'd40, 64'h0, "R6 ES eff held in 64-bit");
    rd(6'd32, 64'h2222, "R6 ES base stored");
    wr(6'd36, 64'h3333);
    rd(6'd44, 64'h3333, "R6 FS eff always copied");
    wr(6'd25, 64'h0);
    rd(6'd40, 64'h2222, "R5 ES eff reloaded");
    rd(6'd43, 64'h4444, "R5 DS eff reloaded");

    // R7 / R8
    wr(6'd22, 64'h0);
    rd(6'd22, 64'hFFFF_0FF0, "R7 DR6 fixed bits");
    wr(6'd20, '1);
    rd(6'd22, 64'hFFFF_EFFF, "R7 DR6 via alias");
    rd(6'd20, 64'hFFFF_EFFF, "R7 alias read");
    wr(6'd21, '1);
    rd(6'd23, 64'hFFFF_24FF, "R8 DR7 via alias");
    wr(6'd23, 64'h0);
    rd(6'd21, 64'h400, "R8 DR7 cleared");
    wr(6'd16, 64'hABCD);
    rd(6'd16, 64'hABCD, "R7 DR0 plain store");

    // R10
    wr(6'd48, 64'd1000);
    rd(6'd48, 64'd1001, "R10 TSC k=1");
    @(negedge clk);
    rd(6'd48, 64'd1002, "R10 TSC k=2");

    // R11
    wr(6'd50, 64'd5);
    wr(6'd49, 64'hFFFF);
    rd(6'd49, 64'hEFFF, "R11 FSW merged top");
    rd(6'd50, 64'd5, "R11 top stored");

    // R12
    wr(6'd5, 64'h1234);
    check("R12 wr_err pulse", {63'd0, s_err}, 64'd1);
    check("R12 no flush", {s_all, s_ng}, 4'b0000);
    rd(6'd5, 64'h0, "R12 reserved reads zero");
    check("R12 rd_err set", {63'd0, rd_err}, 64'd1);
    rd(6'd4, 64'hB1, "R12 CR4 untouched");
    check("R12 rd_err clear", {63'd0, rd_err}, 64'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule